// File: doc/BRIEF.md
# Dual-Select Sensor Serial Responder

This block is a synthesizable device-side model of a sensor's serial port. It lets a host serial controller be tested against real logic. Two active-low select lines divide the traffic. The configuration select frames bytes written into the device. The read select frames a 20-clock output frame that carries one 14-bit sample. Each channel's sample arrives as a parallel input: the offset-binary rate value, the temperature value and two auxiliary values. No conversion physics is modelled.

During a configuration frame, any number of bits may be shifted in on falling SCLK edges. The last eight bits present when the configuration select rises become the control byte. That byte picks the channel that the next read frame reports, and it can switch a self-test mode on or off. While self-test is active, a signed offset input is added to the rate sample or subtracted from it, and the result is clamped to the 14-bit range.

A falling read select freezes the chosen sample. Over the following SCLK falling edges, the output carries five zeros, then the 14 sample bits MSB first, then zeros. The output enable is held low whenever the read select is high. All port activity is oversampled by the block's own clock.

Top module: `sensor_spi_responder`

## Requirements
- R1: After reset the output enable and the data output are both 0, the rate channel is selected and self-test is off.
- R2: While cfgSelN is low, `din` is shifted in on each SCLK falling edge. When cfgSelN rises, the last eight bits shifted in become the control byte. The earliest of those eight bits is bit 7 and the final one is bit 0. More than eight bits may be sent in one frame.
- R3: Control byte 0x20 selects the rate input, 0x10 the temperature input, 0x40 auxiliary input 1 and 0x80 auxiliary input 2. Each of these codes turns self-test off.
- R4: Control byte 0x22 selects rate with positive self-test, which reports rate plus stOffset. Control byte 0x21 selects rate with negative self-test, which reports rate minus stOffset. stOffset is 14-bit two's complement.
- R5: The self-test result is clamped to the range 0 to 16383.
- R6: A control byte other than the six codes above leaves the channel and the self-test state unchanged.
- R7: The reported sample is the value present when rdSelN falls. Later changes to the inputs do not affect that frame.
- R8: Counting SCLK falling edges after rdSelN falls, `dout` is 0 after edges 1 to 5. It carries sample bits 13 down to 0 after edges 6 to 19. It is 0 after edge 20 and after any later edge.
- R9: `doutOe` is 1 from the fall of rdSelN until its rise and 0 otherwise. `dout` is 0 whenever `doutOe` is 0.
- R10: SCLK activity while both selects are high changes neither the channel selection nor the output enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the serial lines |
| rstN | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock from the host |
| cfgSelN | input | 1 | Active-low configuration select; its rising edge loads the control byte |
| rdSelN | input | 1 | Active-low read select; its falling edge freezes the sample |
| din | input | 1 | Serial configuration data |
| rateIn | input | 14 | Rate sample, offset binary |
| tempIn | input | 14 | Temperature sample |
| aux1In | input | 14 | Auxiliary input 1 sample |
| aux2In | input | 14 | Auxiliary input 2 sample |
| stOffset | input | 14 | Signed self-test offset |
| dout | output | 1 | Serial sample data |
| doutOe | output | 1 | Output enable for `dout`; 0 means high impedance |

## Verification
Every line is registered once at the block's clock. A serial edge therefore first shows on `dout` or `doutOe` one cycle after the clock edge that sees it. A new control byte governs any read frame whose select falls at least one cycle after cfgSelN rises. The bench holds each SCLK level and each select change for four clock cycles. It drives inputs and samples outputs on the falling clock edge, so every result has settled well before it is read. Self-test sums and clamps are checked against values worked out by hand in the bench's vector table.

// File: rtl/sensor_spi_pkg.sv
package sensor_spi_pkg;

  localparam int CFG_W = 8;

  typedef enum logic [1:0] {CH_RATE, CH_TEMP, CH_AUX1, CH_AUX2} chan_e;
  typedef enum logic [1:0] {ST_OFF, ST_POS, ST_NEG} st_e;

  // Strobes from the control side to the datapath
  typedef struct packed {
    logic capture;   // freeze a sample at read-select fall
    logic shiftOut;  // present the next sample bit
    logic zeroOut;   // present a padding zero
    logic clearOut;  // read select released
  } strobe_t;

  typedef struct packed {
    logic  hit;
    chan_e chan;
    st_e   st;
  } cfg_t;

  localparam logic [CFG_W-1:0] CODE_RATE     = 8'h20;
  localparam logic [CFG_W-1:0] CODE_TEMP     = 8'h10;
  localparam logic [CFG_W-1:0] CODE_AUX1     = 8'h40;
  localparam logic [CFG_W-1:0] CODE_AUX2     = 8'h80;
  localparam logic [CFG_W-1:0] CODE_RATE_STP = 8'h22;
  localparam logic [CFG_W-1:0] CODE_RATE_STN = 8'h21;

  function automatic cfg_t decodeCfg(input logic [CFG_W-1:0] code);
    cfg_t r;
    r.hit  = 1'b1;
    r.chan = CH_RATE;
    r.st   = ST_OFF;
    case (code)
      CODE_RATE:     r.chan = CH_RATE;
      CODE_TEMP:     r.chan = CH_TEMP;
      CODE_AUX1:     r.chan = CH_AUX1;
      CODE_AUX2:     r.chan = CH_AUX2;
      CODE_RATE_STP: r.st   = ST_POS;
      CODE_RATE_STN: r.st   = ST_NEG;
      default:       r.hit  = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sensor_spi_ctrl.sv
module sensor_spi_ctrl
  import sensor_spi_pkg::*;
#(
  parameter int SAMPLE_W   = 14,
  parameter int LEAD_ZEROS = 5,
  parameter int FRAME_LEN  = 20
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclk,
  input  logic    cfgSelN,
  input  logic    rdSelN,
  input  logic    din,
  output strobe_t strobe,
  output chan_e   chanSel,
  output st_e     stMode,
  output logic    doutOe
);

  localparam int CNT_W     = $clog2(FRAME_LEN + 2);
  localparam int FIRST_BIT = LEAD_ZEROS + 1;
  localparam int LAST_BIT  = LEAD_ZEROS + SAMPLE_W;

  logic             sclkQ, cfgSelQ, rdSelQ;
  logic [CFG_W-1:0] cfgShift;
  chan_e            chanQ;
  st_e              stQ;
  logic [CNT_W-1:0] cnt;
  logic             oeQ;

  logic             sclkFall, cfgRise, rdFall, rdRise, readEdge, inWin;
  logic [CNT_W-1:0] nextCnt;
  cfg_t             cfgDec;

  assign sclkFall = sclkQ & ~sclk;
  assign cfgRise  = ~cfgSelQ & cfgSelN;
  assign rdFall   = rdSelQ & ~rdSelN;
  assign rdRise   = ~rdSelQ & rdSelN;
  assign readEdge = sclkFall & oeQ & ~rdSelN & ~rdFall;
  assign nextCnt  = cnt + 1'b1;
  assign inWin    = (nextCnt >= CNT_W'(FIRST_BIT)) && (nextCnt <= CNT_W'(LAST_BIT));
  assign cfgDec   = decodeCfg(cfgShift);

  always_comb begin
    strobe.capture  = rdFall;
    strobe.shiftOut = readEdge & inWin;
    strobe.zeroOut  = readEdge & ~inWin;
    strobe.clearOut = rdRise;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ    <= 1'b0;
      cfgSelQ  <= 1'b1;
      rdSelQ   <= 1'b1;
      cfgShift <= '0;
      chanQ    <= CH_RATE;
      stQ      <= ST_OFF;
      cnt      <= '0;
      oeQ      <= 1'b0;
    end else begin
      sclkQ   <= sclk;
      cfgSelQ <= cfgSelN;
      rdSelQ  <= rdSelN;
      if (sclkFall && !cfgSelN)
        cfgShift <= {cfgShift[CFG_W-2:0], din};
      if (cfgRise && cfgDec.hit) begin
        chanQ <= cfgDec.chan;
        stQ   <= cfgDec.st;
      end
      if (rdFall) begin
        oeQ <= 1'b1;
        cnt <= '0;
      end else if (rdRise) begin
        oeQ <= 1'b0;
      end else if (readEdge && cnt != CNT_W'(FRAME_LEN)) begin
        cnt <= nextCnt;
      end
    end
  end

  assign chanSel = chanQ;
  assign stMode  = stQ;
  assign doutOe  = oeQ;

  // R9: enable drops once the read select is released
  assert_oe_drop_R9: assert property (@(posedge clk) disable iff (!rstN)
    rdRise |=> !doutOe);

  // R6: unknown byte keeps channel and self-test state
  assert_keep_sel_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRise && !cfgDec.hit) |=> ($stable(chanSel) && $stable(stMode)));

  // R10: selection moves only on a configuration-select rise
  assert_quiet_sel_R10: assert property (@(posedge clk) disable iff (!rstN)
    !cfgRise |=> $stable(chanSel));

endmodule

// File: rtl/sensor_spi_dpath.sv
module sensor_spi_dpath
  import sensor_spi_pkg::*;
#(
  parameter int SAMPLE_W = 14
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobe,
  input  chan_e               chanSel,
  input  st_e                 stMode,
  input  logic [SAMPLE_W-1:0] rateIn,
  input  logic [SAMPLE_W-1:0] tempIn,
  input  logic [SAMPLE_W-1:0] aux1In,
  input  logic [SAMPLE_W-1:0] aux2In,
  input  logic [SAMPLE_W-1:0] stOffset,
  output logic                dout
);

  localparam int SUM_W = SAMPLE_W + 2;
  localparam logic signed [SUM_W-1:0] MAX_CODE = SUM_W'((1 << SAMPLE_W) - 1);

  logic signed [SUM_W-1:0] rateExt, offExt, stSum;
  logic [SAMPLE_W-1:0]     stRate, sample, shiftReg;
  logic                    doutQ;

  assign rateExt = $signed({2'b00, rateIn});
  assign offExt  = $signed({{2{stOffset[SAMPLE_W-1]}}, stOffset});

  always_comb begin
    stSum = (stMode == ST_NEG) ? rateExt - offExt : rateExt + offExt;
    if (stSum < 0)             stRate = '0;
    else if (stSum > MAX_CODE) stRate = MAX_CODE[SAMPLE_W-1:0];
    else                       stRate = stSum[SAMPLE_W-1:0];
  end

  always_comb begin
    case (chanSel)
      CH_TEMP: sample = tempIn;
      CH_AUX1: sample = aux1In;
      CH_AUX2: sample = aux2In;
      default: sample = (stMode == ST_OFF) ? rateIn : stRate;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      doutQ    <= 1'b0;
    end else if (strobe.capture) begin
      shiftReg <= sample;
      doutQ    <= 1'b0;
    end else if (strobe.clearOut) begin
      doutQ <= 1'b0;
    end else if (strobe.shiftOut) begin
      doutQ    <= shiftReg[SAMPLE_W-1];
      shiftReg <= shiftReg << 1;
    end else if (strobe.zeroOut) begin
      doutQ <= 1'b0;
    end
  end

  assign dout = doutQ;

  // R7: a plain rate capture freezes the rate input seen at that edge
  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && chanSel == CH_RATE && stMode == ST_OFF)
      |=> (shiftReg == $past(rateIn)));

  // R5: a non-negative offset never lowers the positive self-test result
  assert_sat_pos_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && chanSel == CH_RATE && stMode == ST_POS && !stOffset[SAMPLE_W-1])
      |=> (shiftReg >= $past(rateIn)));

  // R5: a non-negative offset never raises the negative self-test result
  assert_sat_neg_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && chanSel == CH_RATE && stMode == ST_NEG && !stOffset[SAMPLE_W-1])
      |=> (shiftReg <= $past(rateIn)));

endmodule

// File: rtl/sensor_spi_responder.sv
module sensor_spi_responder
  import sensor_spi_pkg::*;
#(
  parameter int SAMPLE_W   = 14,
  parameter int LEAD_ZEROS = 5,
  parameter int FRAME_LEN  = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclk,
  input  logic                cfgSelN,
  input  logic                rdSelN,
  input  logic                din,
  input  logic [SAMPLE_W-1:0] rateIn,
  input  logic [SAMPLE_W-1:0] tempIn,
  input  logic [SAMPLE_W-1:0] aux1In,
  input  logic [SAMPLE_W-1:0] aux2In,
  input  logic [SAMPLE_W-1:0] stOffset,
  output logic                dout,
  output logic                doutOe
);

  strobe_t strobe;
  chan_e   chanSel;
  st_e     stMode;

  sensor_spi_ctrl #(
    .SAMPLE_W  (SAMPLE_W),
    .LEAD_ZEROS(LEAD_ZEROS),
    .FRAME_LEN (FRAME_LEN)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sclk   (sclk),
    .cfgSelN(cfgSelN),
    .rdSelN (rdSelN),
    .din    (din),
    .strobe (strobe),
    .chanSel(chanSel),
    .stMode (stMode),
    .doutOe (doutOe)
  );

  sensor_spi_dpath #(
    .SAMPLE_W(SAMPLE_W)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .chanSel (chanSel),
    .stMode  (stMode),
    .rateIn  (rateIn),
    .tempIn  (tempIn),
    .aux1In  (aux1In),
    .aux2In  (aux2In),
    .stOffset(stOffset),
    .dout    (dout)
  );

endmodule

// File: tb/sensor_spi_responder_bench.sv
module sensor_spi_responder_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclk = 1'b0;
  logic        cfgSelN = 1'b1;
  logic        rdSelN = 1'b1;
  logic        din = 1'b0;
  logic [13:0] rateIn = '0;
  logic [13:0] tempIn = 14'd7700;
  logic [13:0] aux1In = 14'h3ABC;
  logic [13:0] aux2In = 14'h0155;
  logic [13:0] stOffset = '0;
  logic        dout, doutOe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sensor_spi_responder u_sensor_spi_responder (
    .clk(clk), .rstN(rstN), .sclk(sclk), .cfgSelN(cfgSelN), .rdSelN(rdSelN),
    .din(din), .rateIn(rateIn), .tempIn(tempIn), .aux1In(aux1In),
    .aux2In(aux2In), .stOffset(stOffset), .dout(dout), .doutOe(doutOe)
  );

  // Fields: ctrl[49:42] rate[41:28] offset[27:14] expected[13:0]
  localparam logic [49:0] VEC [11] = '{
    {8'h20, 14'd8192,  14'd0,     14'd8192},   // R3 rate
    {8'h10, 14'd1111,  14'd0,     14'd7700},   // R3 temperature
    {8'h40, 14'd1111,  14'd0,     14'd15036},  // R3 aux1
    {8'h80, 14'd1111,  14'd0,     14'd341},    // R3 aux2
    {8'h22, 14'd9012,  14'd600,   14'd9612},   // R4 positive
    {8'h21, 14'd9012,  14'd600,   14'd8412},   // R4 negative
    {8'h22, 14'd16000, 14'd1000,  14'd16383},  // R5 clamp high
    {8'h21, 14'd300,   14'd1000,  14'd0},      // R5 clamp low
    {8'h21, 14'd300,   14'd15884, 14'd800},    // R4 minus negative
    {8'h22, 14'd5000,  14'd10384, 14'd0},      // R5 clamp low via add
    {8'h20, 14'd10922, 14'd600,   14'd10922}   // R3 self-test off again
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [15:0] bits, input int n);
    cfgSelN = 1'b0;
    tick(4);
    for (int i = n - 1; i >= 0; i--) begin
      din = bits[i];
      sclk = 1'b1; tick(4);
      sclk = 1'b0; tick(4);
    end
    cfgSelN = 1'b1;
    tick(4);
  endtask

  task automatic readFrame(input int nEdges, input bit change, input logic [13:0] newRate,
                           output logic [23:0] got);
    got = '0;
    rdSelN = 1'b0;
    tick(4);
    check("R9 enable on", {30'd0, doutOe, dout}, 32'd2);
    if (change) rateIn = newRate;
    for (int k = 1; k <= nEdges; k++) begin
      sclk = 1'b1; tick(4);
      sclk = 1'b0; tick(4);
      got[24-k] = dout;
    end
    rdSelN = 1'b1;
    tick(4);
    check("R9 enable off", {30'd0, doutOe, dout}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [23:0] got;
    tick(3);
    // R1 reset state
    check("R1 reset outputs", {30'd0, doutOe, dout}, 32'd0);
    rstN = 1'b1;
    tick(2);
    check("R1 after release", {30'd0, doutOe, dout}, 32'd0);
    rateIn = 14'd4660;
    stOffset = 14'd700;
    readFrame(20, 1'b0, '0, got);
    check("R1 default rate no self-test", {8'd0, got}, {8'd0, 5'd0, 14'd4660, 5'd0});

    // Table walk: R3 R4 R5 R8
    for (int v = 0; v < 11; v++) begin
      rateIn = VEC[v][41:28];
      stOffset = VEC[v][27:14];
      cfgWrite({8'h00, VEC[v][49:42]}, 8);
      readFrame(20, 1'b0, '0, got);
      check($sformatf("R8 frame vector %0d", v), {8'd0, got}, {8'd0, 5'd0, VEC[v][13:0], 5'd0});
    end

    // R2: twelve bits sent, last eight are 0x10
    cfgWrite(16'h0F10, 12);
    readFrame(20, 1'b0, '0, got);
    check("R2 long frame keeps last eight", {8'd0, got}, {8'd0, 5'd0, 14'd7700, 5'd0});

    // R6: unknown byte keeps temperature
    cfgWrite(16'h0033, 8);
    readFrame(20, 1'b0, '0, got);
    check("R6 unknown keeps channel", {8'd0, got}, {8'd0, 5'd0, 14'd7700, 5'd0});

    // R6: unknown byte keeps positive self-test
    rateIn = 14'd2000;
    stOffset = 14'd500;
    cfgWrite(16'h0022, 8);
    cfgWrite(16'h0055, 8);
    readFrame(20, 1'b0, '0, got);
    check("R6 unknown keeps self-test", {8'd0, got}, {8'd0, 5'd0, 14'd2500, 5'd0});

    // R7: input change after select fall does not alter frame
    cfgWrite(16'h0020, 8);
    rateIn = 14'd12345;
    readFrame(20, 1'b1, 14'd1, got);
    check("R7 frozen sample", {8'd0, got}, {8'd0, 5'd0, 14'd12345, 5'd0});

    // R8: extra edges beyond twenty give zeros
    rateIn = 14'h3FFF;
    readFrame(24, 1'b0, '0, got);
    check("R8 trailing zeros", {8'd0, got}, {8'd0, 5'd0, 14'h3FFF, 5'd0});

    // R10: SCLK with both selects high, din high
    din = 1'b1;
    for (int k = 0; k < 10; k++) begin
      sclk = 1'b1; tick(4);
      sclk = 1'b0; tick(4);
      if (k == 5) check("R10 enable stays low", {30'd0, doutOe, dout}, 32'd0);
    end
    rateIn = 14'd321;
    readFrame(20, 1'b0, '0, got);
    check("R10 selection unchanged", {8'd0, got}, {8'd0, 5'd0, 14'd321, 5'd0});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule